// File: doc/BRIEF.md
# Unaligned Partial-Word Load Merger

This block executes the left and right halves of an unaligned load on a 64-bit, little-endian register datapath. A caller hands it an effective address, an operation code and the present contents of the destination register. The block clears the low address bits to form an aligned address, makes a single read of that aligned word or doubleword, and combines the returned bytes with the bytes of the old register value that the operation keeps. The merged value comes back as a one-cycle result pulse, ready to be written to the register file.

Any byte address can be loaded by issuing a left-type operation and a right-type operation back to back on the same destination register. The first operation fills part of the register from one aligned container. The second fills the remaining bytes from the neighbouring container and leaves the first operation's bytes untouched. The block accepts only one request at a time.

Top module: `partial_load_merge`

## Requirements
- R1: The read address on `mem_rd_addr` is the request address with its low 2 bits cleared for word operations (`req_op` 0 and 1) and its low 3 bits cleared for doubleword operations (`req_op` 2 and 3). The in-container byte offset is the part of the address that is cleared.
- R2: A request is taken in a cycle where `req_valid` and `req_ready` are both high. `req_ready` then stays low up to and including the cycle of the result pulse, and is high again in the following cycle.
- R3: After acceptance, `mem_rd_valid` is high from the next cycle and holds with a steady `mem_rd_addr` until a cycle in which `mem_rd_ready` is high. Exactly one read is made for each request.
- R4: `res_valid` is high for exactly one cycle, in the cycle after the one in which `mem_rsp_valid` is sampled high while a read is pending.
- R5: Word-left (`req_op`=0). With k = 3 − offset, the low 32 bits of the result are (word << 8k) OR (old[31:0] AND (2^(8k) − 1)). The result is that 32-bit value sign-extended to 64 bits.
- R6: Word-right (`req_op`=1). The low 32 bits of the result are (word >> 8·offset), shifted as an unsigned value, OR (old[31:0] AND mask). The mask is 0xFFFFFFFF << 8·(4 − offset) when the offset is nonzero and 0 when it is zero. Bits 63:32 of the result are zero.
- R7: Doubleword-left (`req_op`=2). With k = 7 − offset, the result is (dword << 8k) OR (old AND (2^(8k) − 1)).
- R8: Doubleword-right (`req_op`=3). The result is (dword >> 8·offset) OR (old AND mask). The mask is all-ones << 8·(8 − offset) when the offset is nonzero and 0 when it is zero.
- R9: Boundary offsets return the whole container. Word-left at offset 3 gives the sign-extended word. Word-right at offset 0 gives the zero-extended word. Doubleword-left at offset 7 and doubleword-right at offset 0 give the doubleword unchanged.
- R10: For word operations the word is taken from `mem_rsp_data[31:0]` and bits 63:32 have no effect. A `mem_rsp_valid` while no read is pending produces no result pulse.
- R11: After reset, `req_ready` is high, `mem_rd_valid` and `res_valid` are low, and `res_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | AW | Effective byte address |
| req_op | input | 2 | 0 word-left, 1 word-right, 2 doubleword-left, 3 doubleword-right |
| req_old | input | 64 | Present destination register value |
| mem_rd_valid | output | 1 | Aligned read request |
| mem_rd_ready | input | 1 | Memory takes the read |
| mem_rd_addr | output | AW | Aligned read address |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 64 | Read data, word operations use bits 31:0 |
| res_valid | output | 1 | One-cycle result pulse |
| res_data | output | 64 | Merged write-back value |

## Verification
The bench targets every offset of all four operations. A mask that is off by one byte would pass the full-container offsets and corrupt a byte at the others. A right-type operation at offset zero shifts the mask by the full container width, and a design that does not special-case it keeps stale register bytes. Word operations are driven with a negative word and with junk in the upper half of the response, which catches a missing sign extension on the left variant and upper bits that leak through on the right variant. Randomised handshake delays and a stray response while idle expose a read address that changes before it is accepted, a duplicate read, and a spurious result pulse.

// File: rtl/plm_pkg.sv
// Shared types for the partial-word load merger.
// Bit 1 of the op selects doubleword size and bit 0 selects the right variant;
// the merge and align logic decode those two bits directly.
package plm_pkg;
    typedef enum logic [1:0] {
        OP_WORD_L = 2'd0,
        OP_WORD_R = 2'd1,
        OP_DWRD_L = 2'd2,
        OP_DWRD_R = 2'd3
    } ldop_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE
    } plm_state_e;
endpackage

// File: rtl/plm_align.sv
// Splits an effective address into the aligned container address and the
// byte offset inside that container. Assumes the container is 4 bytes for
// word ops and 8 bytes for doubleword ops, and that AW >= 4.
module plm_align #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] addr,
    input  logic          is_dword,
    output logic [2:0]    offset,
    output logic [AW-1:0] aligned
);
    logic [2:0] low_mask;

    // Offset mask is size-1: 3 for words, 7 for doublewords.
    always_comb begin
        low_mask = is_dword ? 3'b111 : 3'b011;
        offset   = addr[2:0] & low_mask;
        aligned  = {addr[AW-1:3], addr[2:0] & ~low_mask};
    end
endmodule

// File: rtl/plm_merge.sv
// Byte-lane merge of returned memory data with the kept bytes of the old
// register. Each result lane picks either a memory lane or an old lane
// depending on the op and offset. Assumes DW is a multiple of 16 and that
// offset is already reduced to the container size.
module plm_merge
    import plm_pkg::*;
#(
    parameter int DW = 64
) (
    input  ldop_e         op,
    input  logic [2:0]    offset,
    input  logic [DW-1:0] mem,
    input  logic [DW-1:0] old,
    output logic [DW-1:0] merged
);
    localparam int NB = DW / 8;
    localparam int HW = DW / 2;

    logic [DW-1:0] lanes;

    // Lane selection: left ops shift memory up, right ops shift it down.
    always_comb begin
        int nb;
        int off_i;
        int k;
        off_i = int'(offset);
        nb    = op[1] ? NB : NB / 2;
        k     = nb - 1 - off_i;
        lanes = '0;
        for (int i = 0; i < NB; i++) begin
            if (i < nb) begin
                if (!op[0]) begin
                    if (i < k) lanes[8*i +: 8] = old[8*i +: 8];
                    else       lanes[8*i +: 8] = mem[8*(i-k) +: 8];
                end else begin
                    if (i < nb - off_i) lanes[8*i +: 8] = mem[8*(i+off_i) +: 8];
                    else                lanes[8*i +: 8] = old[8*i +: 8];
                end
            end
        end
    end

    // Word-left sign-extends; word-right leaves the upper half zero.
    always_comb begin
        merged = lanes;
        if (op == OP_WORD_L) merged[DW-1:HW] = {HW{lanes[HW-1]}};
    end
endmodule

// File: rtl/plm_ctrl.sv
// Request sequencer: accept, issue one aligned read, wait for its data,
// pulse the result. Assumes the memory returns exactly one response per
// accepted read and that responses outside a pending read are spurious.
module plm_ctrl
    import plm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic mem_rd_ready,
    input  logic mem_rsp_valid,
    output logic req_ready,
    output logic mem_rd_valid,
    output logic take_req,
    output logic take_rsp,
    output logic res_valid
);
    plm_state_e state;

    // Decoded handshake strobes for the datapath registers.
    always_comb begin
        req_ready    = (state == ST_IDLE);
        mem_rd_valid = (state == ST_ISSUE);
        res_valid    = (state == ST_DONE);
        take_req     = req_ready && req_valid;
        take_rsp     = (state == ST_WAIT) && mem_rsp_valid;
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE:  if (req_valid)     state <= ST_ISSUE;
                ST_ISSUE: if (mem_rd_ready)  state <= ST_WAIT;
                ST_WAIT:  if (mem_rsp_valid) state <= ST_DONE;
                default:                     state <= ST_IDLE;
            endcase
        end
    end

    // R2: busy from acceptance onward.
    a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    // R2: idle again right after the result pulse.
    a_r2_ready_after_result: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> req_ready);
    // R3: read request held until taken.
    a_r3_read_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ready) |=> mem_rd_valid);
    // R4: result is a single-cycle pulse following the response.
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);
    a_r4_result_follows_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        (take_rsp) |=> res_valid);
endmodule

// File: rtl/partial_load_merge.sv
// Top of the unaligned partial-word load merger. Captures one request,
// issues its aligned read, and registers the merged write-back value.
// Assumes a 64-bit register and response width and a byte address of AW bits.
module partial_load_merge
    import plm_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic [1:0]    req_op,
    input  logic [DW-1:0] req_old,
    output logic          mem_rd_valid,
    input  logic          mem_rd_ready,
    output logic [AW-1:0] mem_rd_addr,
    input  logic          mem_rsp_valid,
    input  logic [DW-1:0] mem_rsp_data,
    output logic          res_valid,
    output logic [DW-1:0] res_data
);
    localparam int HW = DW / 2;

    logic          take_req;
    logic          take_rsp;
    ldop_e         op_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] old_q;
    logic [2:0]    offset;
    logic [DW-1:0] mem_in;
    logic [DW-1:0] merged;

    plm_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .mem_rd_ready (mem_rd_ready),
        .mem_rsp_valid(mem_rsp_valid),
        .req_ready    (req_ready),
        .mem_rd_valid (mem_rd_valid),
        .take_req     (take_req),
        .take_rsp     (take_rsp),
        .res_valid    (res_valid)
    );

    plm_align #(.AW(AW)) u_align (
        .addr    (addr_q),
        .is_dword(op_q[1]),
        .offset  (offset),
        .aligned (mem_rd_addr)
    );

    // Word ops see only the low half of the response.
    always_comb begin
        mem_in = mem_rsp_data;
        if (!op_q[1]) mem_in[DW-1:HW] = '0;
    end

    plm_merge #(.DW(DW)) u_merge (
        .op    (op_q),
        .offset(offset),
        .mem   (mem_in),
        .old   (old_q),
        .merged(merged)
    );

    // Request capture on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_WORD_L;
            addr_q <= '0;
            old_q  <= '0;
        end else if (take_req) begin
            op_q   <= ldop_e'(req_op);
            addr_q <= req_addr;
            old_q  <= req_old;
        end
    end

    // Result register loaded when the read data arrives.
    always_ff @(posedge clk) begin
        if (!rst_n)        res_data <= '0;
        else if (take_rsp) res_data <= merged;
    end

    // R1: the read address carries no in-container offset and matches the request.
    a_r1_aligned_addr: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> (mem_rd_addr[1:0] == 2'b00) &&
                         (!op_q[1] || mem_rd_addr[2] == 1'b0) &&
                         (mem_rd_addr[AW-1:3] == addr_q[AW-1:3]));
    // R3: read address steady while waiting to be taken.
    a_r3_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ready) |=> $stable(mem_rd_addr));
    // R5: word-left results are sign-extended.
    a_r5_sext: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && op_q == OP_WORD_L) |-> (res_data[DW-1:HW] == {HW{res_data[HW-1]}}));
    // R6: word-right results have a zero upper half.
    a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && op_q == OP_WORD_R) |-> (res_data[DW-1:HW] == '0));
endmodule

// File: tb/tb_partial_load_merge.sv
module tb_partial_load_merge;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid;
    logic          req_ready;
    logic [AW-1:0] req_addr;
    logic [1:0]    req_op;
    logic [63:0]   req_old;
    logic          mem_rd_valid;
    logic          mem_rd_ready;
    logic [AW-1:0] mem_rd_addr;
    logic          mem_rsp_valid;
    logic [63:0]   mem_rsp_data;
    logic          res_valid;
    logic [63:0]   res_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    partial_load_merge #(.AW(AW), .DW(64)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_op(req_op), .req_old(req_old),
        .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
        .mem_rd_addr(mem_rd_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .res_valid(res_valid), .res_data(res_data)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Expected result from the shift/mask formulas of R5 to R8.
    function automatic logic [63:0] model(input logic [1:0] op, input logic [AW-1:0] a,
                                          input logic [63:0] old, input logic [63:0] mem);
        logic [31:0] w, m32, v32;
        logic [63:0] m64;
        int off, k;
        w = mem[31:0];
        case (op)
            2'd0: begin
                off = int'(a[1:0]); k = 3 - off;
                m32 = (32'h1 << (8*k)) - 32'h1;
                v32 = (w << (8*k)) | (old[31:0] & m32);
                return {{32{v32[31]}}, v32};
            end
            2'd1: begin
                off = int'(a[1:0]);
                m32 = (off != 0) ? (32'hFFFF_FFFF << (8*(4-off))) : 32'h0;
                v32 = (w >> (8*off)) | (old[31:0] & m32);
                return {32'h0, v32};
            end
            2'd2: begin
                off = int'(a[2:0]); k = 7 - off;
                m64 = (64'h1 << (8*k)) - 64'h1;
                return (mem << (8*k)) | (old & m64);
            end
            default: begin
                off = int'(a[2:0]);
                m64 = (off != 0) ? ({64{1'b1}} << (8*(8-off))) : 64'h0;
                return (mem >> (8*off)) | (old & m64);
            end
        endcase
    endfunction

    // One full load transaction; exp is the expected write-back value.
    task automatic do_load(input string tag, input logic [1:0] op, input logic [AW-1:0] a,
                           input logic [63:0] old, input logic [63:0] mem,
                           input logic [63:0] exp, input int rdly, input int sdly);
        logic [AW-1:0] exp_addr;
        exp_addr = op[1] ? {a[AW-1:3], 3'b000} : {a[AW-1:2], 2'b00};
        @(negedge clk);
        check("R2 ready before request", {63'b0, req_ready}, 64'd1);
        req_valid = 1'b1; req_addr = a; req_op = op; req_old = old;
        @(negedge clk);
        req_valid = 1'b0; req_addr = '1; req_old = '0;
        check("R2 busy after accept", {63'b0, req_ready}, 64'd0);
        for (int i = 0; i < rdly; i++) begin
            check("R3 read held", {63'b0, mem_rd_valid}, 64'd1);
            check("R3 read address steady", {32'b0, mem_rd_addr}, {32'b0, exp_addr});
            @(negedge clk);
        end
        check("R3 read valid", {63'b0, mem_rd_valid}, 64'd1);
        check({"R1 aligned address ", tag}, {32'b0, mem_rd_addr}, {32'b0, exp_addr});
        mem_rd_ready = 1'b1;
        @(negedge clk);
        mem_rd_ready = 1'b0;
        check("R3 single read", {63'b0, mem_rd_valid}, 64'd0);
        for (int i = 0; i < sdly; i++) begin
            check("R4 no early result", {63'b0, res_valid}, 64'd0);
            @(negedge clk);
        end
        mem_rsp_valid = 1'b1; mem_rsp_data = mem;
        @(negedge clk);
        mem_rsp_valid = 1'b0; mem_rsp_data = '0;
        check("R4 result pulse", {63'b0, res_valid}, 64'd1);
        check("R2 busy during result", {63'b0, req_ready}, 64'd0);
        check(tag, res_data, exp);
        @(negedge clk);
        check("R4 pulse ends", {63'b0, res_valid}, 64'd0);
        check("R2 ready after result", {63'b0, req_ready}, 64'd1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R11 req_ready", {63'b0, req_ready}, 64'd1);
        check("R11 mem_rd_valid", {63'b0, mem_rd_valid}, 64'd0);
        check("R11 res_valid", {63'b0, res_valid}, 64'd0);
        check("R11 res_data", res_data, 64'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_word_left();
        logic [63:0] mem, old;
        mem = 64'hDEAD_BEEF_8899_AABB;
        old = 64'h0123_4567_1122_3344;
        for (int off = 0; off < 4; off++) begin
            logic [AW-1:0] a;
            a = 32'h0000_1044 + AW'(off);
            do_load("R5 word-left", 2'd0, a, old, mem, model(2'd0, a, old, mem), off, off % 2);
        end
        mem = 64'h5555_5555_1234_5678;
        do_load("R5 word-left positive", 2'd0, 32'h2001, old, mem, model(2'd0, 32'h2001, old, mem), 0, 0);
    endtask

    task automatic t_word_right();
        logic [63:0] mem, old;
        mem = 64'hFFFF_0000_A1B2_C3D4;
        old = 64'h9999_8888_E5F6_0718;
        for (int off = 0; off < 4; off++) begin
            logic [AW-1:0] a;
            a = 32'h0000_3040 + AW'(off);
            do_load("R6 word-right", 2'd1, a, old, mem, model(2'd1, a, old, mem), 1, off);
        end
    endtask

    task automatic t_dword_left();
        logic [63:0] mem, old;
        mem = 64'h0102_0304_0506_0708;
        old = 64'hF1E2_D3C4_B5A6_9788;
        for (int off = 0; off < 8; off++) begin
            logic [AW-1:0] a;
            a = 32'h0000_5008 + AW'(off);
            do_load("R7 dword-left", 2'd2, a, old, mem, model(2'd2, a, old, mem), off % 3, 2);
        end
    endtask

    task automatic t_dword_right();
        logic [63:0] mem, old;
        mem = 64'h8877_6655_4433_2211;
        old = 64'h0F0E_0D0C_0B0A_0908;
        for (int off = 0; off < 8; off++) begin
            logic [AW-1:0] a;
            a = 32'h0000_7010 + AW'(off);
            do_load("R8 dword-right", 2'd3, a, old, mem, model(2'd3, a, old, mem), 0, off % 4);
        end
    endtask

    // Literal expectations for the whole-container offsets.
    task automatic t_full();
        do_load("R9 word-left offset 3", 2'd0, 32'h0000_0103, 64'hFFFF_FFFF_FFFF_FFFF,
                64'h1234_5678_8899_AABB, 64'hFFFF_FFFF_8899_AABB, 0, 0);
        do_load("R9 word-right offset 0", 2'd1, 32'h0000_0104, 64'hFFFF_FFFF_FFFF_FFFF,
                64'hCAFE_F00D_1122_3344, 64'h0000_0000_1122_3344, 0, 0);
        do_load("R9 dword-left offset 7", 2'd2, 32'h0000_0207, 64'h0000_0000_0000_0000,
                64'hA0B1_C2D3_E4F5_0617, 64'hA0B1_C2D3_E4F5_0617, 1, 1);
        do_load("R9 dword-right offset 0", 2'd3, 32'h0000_0208, 64'hFFFF_FFFF_FFFF_FFFF,
                64'h2837_4655_6473_8291, 64'h2837_4655_6473_8291, 1, 1);
    endtask

    // R10: upper response half ignored for word ops; stray response while idle.
    task automatic t_ignore();
        do_load("R10 word upper half ignored", 2'd1, 32'h0000_0902, 64'h0,
                64'hFFFF_FFFF_0000_ABCD, 64'h0000_0000_0000_0000, 0, 0);
        @(negedge clk);
        mem_rsp_valid = 1'b1; mem_rsp_data = 64'h1111_2222_3333_4444;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        check("R10 stray response no pulse", {63'b0, res_valid}, 64'd0);
        check("R10 stray response keeps result", res_data, 64'h0000_0000_0000_0000);
        check("R10 stray response ready", {63'b0, req_ready}, 64'd1);
    endtask

    initial begin
        req_valid = 1'b0; req_addr = '0; req_op = '0; req_old = '0;
        mem_rd_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
        t_reset();
        t_word_left();
        t_word_right();
        t_dword_left();
        t_dword_right();
        t_full();
        t_ignore();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule